// File: doc/BRIEF.md
# Serial Divider Configuration Port

This block is the write-only programming port of a dual-loop frequency synthesizer. A host drives three wires: a serial data line, a serial clock and an active-low frame enable. All three are sampled on the fast system clock. While the enable is low, every rising edge of the serial clock shifts one data bit into a 19-bit frame register. When the enable returns high, the last three bits received are decoded as an address. The sixteen bits before them are copied into one of four configuration words. The block then hands the decoded coefficients to the dividers and charge pumps.

Divider coefficients never reach a divider in the middle of a count. Each written ratio is first parked in a pending register. The divider that uses it takes it only in the cycle that divider reports its terminal count. The charge-pump and oscillator bits read no count, so they take effect as soon as the frame is decoded. The port carries no data stream, so it has no valid/ready handshake and no back-pressure. The host controls pacing by how fast it toggles the serial clock, which must have a period of at least five system clocks.

Top module: `cfg_port`

## Requirements
- R1: Serial clock edges and data are ignored while `cfg_en_n` is high; bits shift only on rising `cfg_clk` edges while `cfg_en_n` is low.
- R2: Only the last 19 bits of a frame are kept; any earlier leading bits are discarded, and the bit count is not checked.
- R3: Positions are numbered in reception order 0..18. Positions 0..15 form the data field and positions 16..18 form the address, with position 16 the address MSB. Decoding happens when `cfg_en_n` rises.
- R4: Each rise of `cfg_en_n` gives at most one single-cycle load into the word selected by the address. Addresses 100 to 111 change no output.
- R5: Address 000 writes the 16-bit RF ratio. Data position i is ratio bit i, so the first bit received is the LSB.
- R6: Address 010 writes the 14-bit IF ratio from data positions 0..13, LSB first. Positions 14 and 15 are ignored.
- R7: Address 001 writes the reference word. Positions 0..9 hold the 10-bit common ratio, LSB first. Position 11 holds the routing select. Positions 12..15 hold the 4-bit subdivider code, LSB first; the subdivider then divides by the code plus one. Position 10 is ignored.
- R8: Address 011 writes the control word. Position 4 sets the high charge-pump current, position 5 the double gain and position 6 the oscillator enable, each effective right after decoding. Test bits at positions 0..3 and the other positions have no effect.
- R9: After reset the outputs read RF ratio 512, IF ratio 128, common ratio 8, subdivider code 0, routing 0 and all control bits 0.
- R10: A divider output changes only in a cycle where its terminal-count input is high and a write is pending. When several writes arrive before the terminal count, the last one is applied. A terminal count with nothing pending changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-on preset) |
| cfg_clk | input | 1 | Serial clock, asynchronous |
| cfg_dat | input | 1 | Serial data, asynchronous |
| cfg_en_n | input | 1 | Active-low frame enable, asynchronous |
| rf_tc | input | 1 | RF divider terminal count |
| if_tc | input | 1 | IF divider terminal count |
| ref_tc | input | 1 | Reference divider terminal count |
| rf_ratio | output | 16 | RF main division ratio |
| if_ratio | output | 14 | IF main division ratio |
| ref_ratio | output | 10 | Common reference division ratio |
| sub_code | output | 4 | Subdivider code (divide by code + 1) |
| route_sel | output | 1 | Selects which loop gets the subdivided reference |
| cp_hi | output | 1 | High charge-pump current |
| cp_dbl | output | 1 | Double charge-pump gain |
| osc_en | output | 1 | Oscillator amplifier enable |

## Verification
Several properties are checked on every cycle. Divider coefficients move only at their own terminal count, and the control bits move only on a control load. The frame register stays frozen while the enable is idle, and a decode pulse selects at most one word and lasts one cycle. Bit ordering cannot be seen by any property. That covers LSB-first coefficients, the position of each field, discarded leading bits, ignored address codes and test bits, and the rule that the last pending write wins. Only the scenarios show these, comparing each output change against values the bench builds from the frame layout.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int DATA_W  = 16;
  localparam int ADDR_W  = 3;
  localparam int FRAME_W = DATA_W + ADDR_W;

  typedef enum logic [ADDR_W-1:0] {
    ADR_RF  = 3'b000,
    ADR_REF = 3'b001,
    ADR_IF  = 3'b010,
    ADR_CTL = 3'b011
  } cfg_addr_e;

  localparam int TEST_W    = 4;
  localparam int CPHI_POS  = TEST_W;
  localparam int CPDBL_POS = TEST_W + 1;
  localparam int OSC_POS   = TEST_W + 2;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
    end else begin
      stg[0] <= d_in;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cfg_shift.sv
module cfg_shift #(
  parameter int FRAME_W = 19
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_en,
  input  logic               bit_in,
  output logic [FRAME_W-1:0] frame
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        frame <= '0;
    else if (shift_en) frame <= {frame[FRAME_W-2:0], bit_in};
  end
endmodule

// File: rtl/cfg_shadow.sv
module cfg_shadow #(
  parameter int W = 16,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         tc,
  output logic [W-1:0] q
);
  logic [W-1:0] pend;
  logic         pend_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend   <= RST_VAL;
      pend_v <= 1'b0;
      q      <= RST_VAL;
    end else begin
      if (wr) begin
        pend   <= wdata;
        pend_v <= 1'b1;
      end else if (tc) begin
        pend_v <= 1'b0;
      end
      if (tc && pend_v) q <= pend;
    end
  end
endmodule

// File: rtl/cfg_port.sv
module cfg_port
  import cfg_pkg::*;
#(
  parameter int RF_W  = 16,
  parameter int IF_W  = 14,
  parameter int REF_W = 10,
  parameter int SUB_W = 4,
  parameter int SYNC_STAGES = 2,
  parameter logic [RF_W-1:0]  RF_RST  = RF_W'(512),
  parameter logic [IF_W-1:0]  IF_RST  = IF_W'(128),
  parameter logic [REF_W-1:0] REF_RST = REF_W'(8),
  parameter logic [SUB_W-1:0] SUB_RST = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_clk,
  input  logic             cfg_dat,
  input  logic             cfg_en_n,
  input  logic             rf_tc,
  input  logic             if_tc,
  input  logic             ref_tc,
  output logic [RF_W-1:0]  rf_ratio,
  output logic [IF_W-1:0]  if_ratio,
  output logic [REF_W-1:0] ref_ratio,
  output logic [SUB_W-1:0] sub_code,
  output logic             route_sel,
  output logic             cp_hi,
  output logic             cp_dbl,
  output logic             osc_en
);
  localparam int SUB_POS   = DATA_W - SUB_W;
  localparam int ROUTE_POS = SUB_POS - 1;
  localparam int REFPK_W   = 1 + SUB_W + REF_W;

  // synchronized pins: bit 0 serial clock, bit 1 data, bit 2 enable
  logic [2:0] pins_s;
  cfg_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_in({cfg_en_n, cfg_dat, cfg_clk}),
    .q(pins_s)
  );

  logic sclk_d, en_d;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      en_d   <= 1'b1;
    end else begin
      sclk_d <= pins_s[0];
      en_d   <= pins_s[2];
    end
  end

  logic en_idle, shift_en, load_stb;
  assign en_idle  = pins_s[2];
  assign shift_en = pins_s[0] & ~sclk_d & ~en_idle;
  assign load_stb = en_idle & ~en_d;

  logic [FRAME_W-1:0] frame;
  cfg_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .shift_en(shift_en), .bit_in(pins_s[1]),
    .frame(frame)
  );

  // address decode
  logic [ADDR_W-1:0] adr;
  logic ld_rf, ld_ref, ld_if, ld_ctl;
  logic [3:0] ld_vec;
  assign adr    = frame[ADDR_W-1:0];
  assign ld_rf  = load_stb && (adr == ADR_RF);
  assign ld_ref = load_stb && (adr == ADR_REF);
  assign ld_if  = load_stb && (adr == ADR_IF);
  assign ld_ctl = load_stb && (adr == ADR_CTL);
  assign ld_vec = {ld_ctl, ld_if, ld_ref, ld_rf};

  // data position p (reception order) sits at frame[FRAME_W-1-p]
  logic [DATA_W-1:0] dpos;
  for (genvar p = 0; p < DATA_W; p++) begin : g_pos
    assign dpos[p] = frame[FRAME_W-1-p];
  end

  logic [REFPK_W-1:0] ref_wdata, ref_q;
  assign ref_wdata = {dpos[ROUTE_POS], dpos[SUB_POS +: SUB_W], dpos[REF_W-1:0]};

  cfg_shadow #(.W(RF_W), .RST_VAL(RF_RST)) u_rf (
    .clk(clk), .rst_n(rst_n), .wr(ld_rf), .wdata(dpos[RF_W-1:0]),
    .tc(rf_tc), .q(rf_ratio)
  );

  cfg_shadow #(.W(IF_W), .RST_VAL(IF_RST)) u_if (
    .clk(clk), .rst_n(rst_n), .wr(ld_if), .wdata(dpos[IF_W-1:0]),
    .tc(if_tc), .q(if_ratio)
  );

  cfg_shadow #(.W(REFPK_W), .RST_VAL({1'b0, SUB_RST, REF_RST})) u_ref (
    .clk(clk), .rst_n(rst_n), .wr(ld_ref), .wdata(ref_wdata),
    .tc(ref_tc), .q(ref_q)
  );

  assign route_sel = ref_q[REFPK_W-1];
  assign sub_code  = ref_q[REF_W +: SUB_W];
  assign ref_ratio = ref_q[REF_W-1:0];

  // control word applies at once; test positions are not kept
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cp_hi  <= 1'b0;
      cp_dbl <= 1'b0;
      osc_en <= 1'b0;
    end else if (ld_ctl) begin
      cp_hi  <= dpos[CPHI_POS];
      cp_dbl <= dpos[CPDBL_POS];
      osc_en <= dpos[OSC_POS];
    end
  end
endmodule

// File: rtl/cfg_port_chk.sv
module cfg_port_chk #(
  parameter int RF_W = 16,
  parameter int IF_W = 14,
  parameter int REF_W = 10,
  parameter int SUB_W = 4,
  parameter int FRAME_W = 19
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rf_tc,
  input logic             if_tc,
  input logic             ref_tc,
  input logic [RF_W-1:0]  rf_ratio,
  input logic [IF_W-1:0]  if_ratio,
  input logic [REF_W-1:0] ref_ratio,
  input logic [SUB_W-1:0] sub_code,
  input logic             route_sel,
  input logic [2:0]       ctl,
  input logic             en_idle,
  input logic [FRAME_W-1:0] frame,
  input logic [3:0]       ld_vec,
  input logic             ld_ctl,
  input logic             load_stb
);
  AST_RF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rf_tc |=> $stable(rf_ratio)); // R10
  AST_IF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !if_tc |=> $stable(if_ratio)); // R10
  AST_REF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_tc |=> $stable({route_sel, sub_code, ref_ratio})); // R7
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_ctl |=> $stable(ctl)); // R8
  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    en_idle |=> $stable(frame)); // R1
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ld_vec)); // R4
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> !load_stb); // R4
endmodule

bind cfg_port cfg_port_chk #(
  .RF_W(RF_W), .IF_W(IF_W), .REF_W(REF_W), .SUB_W(SUB_W), .FRAME_W(cfg_pkg::FRAME_W)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .rf_tc(rf_tc), .if_tc(if_tc), .ref_tc(ref_tc),
  .rf_ratio(rf_ratio), .if_ratio(if_ratio), .ref_ratio(ref_ratio),
  .sub_code(sub_code), .route_sel(route_sel),
  .ctl({cp_hi, cp_dbl, osc_en}),
  .en_idle(en_idle), .frame(frame), .ld_vec(ld_vec),
  .ld_ctl(ld_ctl), .load_stb(load_stb)
);

// File: tb/cfg_port_test.sv
module cfg_port_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic cfg_clk = 1'b0, cfg_dat = 1'b0, cfg_en_n = 1'b1;
  logic rf_tc = 1'b0, if_tc = 1'b0, ref_tc = 1'b0;
  logic [15:0] rf_ratio;
  logic [13:0] if_ratio;
  logic [9:0]  ref_ratio;
  logic [3:0]  sub_code;
  logic route_sel, cp_hi, cp_dbl, osc_en;

  cfg_port uut (
    .clk(clk), .rst_n(rst_n), .cfg_clk(cfg_clk), .cfg_dat(cfg_dat), .cfg_en_n(cfg_en_n),
    .rf_tc(rf_tc), .if_tc(if_tc), .ref_tc(ref_tc),
    .rf_ratio(rf_ratio), .if_ratio(if_ratio), .ref_ratio(ref_ratio),
    .sub_code(sub_code), .route_sel(route_sel),
    .cp_hi(cp_hi), .cp_dbl(cp_dbl), .osc_en(osc_en)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct { int kind; int val; string req; } exp_t;
  exp_t sb[$];
  localparam int K_RF = 0, K_IF = 1, K_REF = 2, K_CTL = 3;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic expect_item(input int kind, input int val, input string req);
    exp_t e;
    e.kind = kind; e.val = val; e.req = req;
    sb.push_back(e);
  endtask

  function automatic int ref_pack();
    return (int'(route_sel) << 14) | (int'(sub_code) << 10) | int'(ref_ratio);
  endfunction
  function automatic int ctl_pack();
    return (int'(cp_hi) << 2) | (int'(cp_dbl) << 1) | int'(osc_en);
  endfunction

  // monitor: every output change must match the head of the scoreboard
  int p_rf, p_if, p_ref, p_ctl;
  task automatic observe(input int kind, input int val);
    exp_t e;
    n_chk++;
    if (sb.size() == 0) begin
      n_fail++;
      $display("FAIL R10 unexpected change kind %0d actual %0h expected none", kind, val);
    end else begin
      e = sb.pop_front();
      if (e.kind != kind || e.val != val) begin
        n_fail++;
        $display("FAIL %s kind %0d actual %0h expected kind %0d value %0h",
                 e.req, kind, val, e.kind, e.val);
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (int'(rf_ratio) != p_rf)  observe(K_RF, int'(rf_ratio));
      if (int'(if_ratio) != p_if)  observe(K_IF, int'(if_ratio));
      if (ref_pack() != p_ref)     observe(K_REF, ref_pack());
      if (ctl_pack() != p_ctl)     observe(K_CTL, ctl_pack());
    end
    p_rf = int'(rf_ratio); p_if = int'(if_ratio);
    p_ref = ref_pack();    p_ctl = ctl_pack();
  end

  // frame in reception order: data position p goes out p-th, then address MSB first
  function automatic logic [18:0] mk(input logic [2:0] adr, input logic [15:0] pos);
    logic [18:0] f;
    for (int p = 0; p < 16; p++) f[18-p] = pos[p];
    f[2:0] = adr;
    return f;
  endfunction

  task automatic shift_bits(input logic [31:0] bits, input int n, input logic en_low);
    cfg_en_n = ~en_low;
    repeat (4) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      cfg_dat = bits[i];
      repeat (3) @(negedge clk);
      cfg_clk = 1'b1;
      repeat (3) @(negedge clk);
      cfg_clk = 1'b0;
    end
    repeat (3) @(negedge clk);
    cfg_en_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic send(input logic [2:0] adr, input logic [15:0] pos);
    shift_bits({13'd0, mk(adr, pos)}, 19, 1'b1);
  endtask

  task automatic pulse(input int which);
    case (which)
      K_RF:  rf_tc = 1'b1;
      K_IF:  if_tc = 1'b1;
      default: ref_tc = 1'b1;
    endcase
    @(negedge clk);
    rf_tc = 1'b0; if_tc = 1'b0; ref_tc = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic report();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual hung expected completion");
    report();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R9 reset defaults
    check("R9 rf", rf_ratio, 512);
    check("R9 if", if_ratio, 128);
    check("R9 ref", ref_ratio, 8);
    check("R9 sub", sub_code, 0);
    check("R9 route", route_sel, 0);
    check("R9 ctl", ctl_pack(), 0);

    // R5 RF ratio LSB first, applied only at terminal count (R10)
    send(3'b000, 16'h1234);
    check("R10 rf held before tc", rf_ratio, 512);
    pulse(K_IF);
    check("R10 rf held on other tc", rf_ratio, 512);
    expect_item(K_RF, 16'h1234, "R5");
    pulse(K_RF);

    // R6 IF ratio: positions 14,15 ignored
    send(3'b010, 16'hEABC);
    check("R10 if held before tc", if_ratio, 128);
    expect_item(K_IF, 14'h2ABC, "R6");
    pulse(K_IF);

    // R7 reference word: ratio 0x3A5, position 10 set, route 1, code 9
    send(3'b001, 16'h03A5 | 16'h0400 | 16'h0800 | (16'd9 << 12));
    check("R7 ref held before tc", ref_ratio, 8);
    expect_item(K_REF, (1 << 14) | (9 << 10) | 10'h3A5, "R7");
    pulse(K_REF);

    // R8 control word applies without a terminal count
    expect_item(K_CTL, 3'b101, "R8");
    send(3'b011, 16'h0050);
    check("R8 ctl", ctl_pack(), 3'b101);
    send(3'b011, 16'h005F);
    check("R8 test bits no effect", ctl_pack(), 3'b101);

    // R1 clocks while enable idle are ignored
    shift_bits({13'd0, mk(3'b000, 16'h0F0F)}, 19, 1'b0);
    pulse(K_RF);
    check("R1 idle clocks ignored", rf_ratio, 16'h1234);

    // R2 extra leading bits dropped
    shift_bits({9'd0, 4'b1011, mk(3'b000, 16'hBEEF)}, 23, 1'b1);
    expect_item(K_RF, 16'hBEEF, "R2");
    pulse(K_RF);

    // R4 unused addresses discarded
    send(3'b101, 16'h5555);
    send(3'b111, 16'hFFFF);
    pulse(K_RF); pulse(K_IF); pulse(K_REF);
    check("R4 rf", rf_ratio, 16'hBEEF);
    check("R4 if", if_ratio, 14'h2ABC);
    check("R4 ref", ref_pack(), (1 << 14) | (9 << 10) | 10'h3A5);
    check("R4 ctl", ctl_pack(), 3'b101);

    // R3 address is MSB first: reversed control code 110 is unused
    send(3'b110, 16'h0000);
    check("R3 address order", ctl_pack(), 3'b101);

    // R10 last pending write wins
    send(3'b000, 16'h0777);
    send(3'b000, 16'h0999);
    check("R10 rf held", rf_ratio, 16'hBEEF);
    expect_item(K_RF, 16'h0999, "R10");
    pulse(K_RF);
    pulse(K_RF);

    repeat (4) @(negedge clk);
    check("R10 scoreboard drained", sb.size(), 0);
    report();
  end
endmodule